// File: doc/BRIEF.md
# Keyed Software Watchdog

This block is a system-protection watchdog that runs from the system clock. Software keeps it from expiring by writing two fixed key words to a service port, and they must arrive in order. A down-counter starts from a programmed count. When it passes zero, the block raises either a non-maskable interrupt request or a system reset request. A 32-bit control word sets the count, the enable, the behaviour during debug halt, the choice of timeout action and an optional fixed prescaler. The control word also stores a timing byte and an enable bit for a separate bus monitor. This block does not use those two fields.

The control word can be written once after reset. Every later write is dropped, so a program that runs away cannot switch protection off. Reading the control word returns the live counter value in its count field.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control readback is 0xFFFF_FF07: count 0xFFFF in bits 31:16, bus timing 0xFF in bits 15:8, bus-monitor enable (bit 7) 0, bits 6:4 zero, freeze-mode (bit 3) 0, enable (bit 2) 1, select (bit 1) 1, prescale (bit 0) 1. Both request outputs are low.
- R2: The first control write after reset stores the fields, forces bits 6:4 to zero and loads the counter from bits 31:16 on that edge. Every later control write is ignored until the next reset.
- R3: When enabled, not frozen and with prescale 0, the counter drops by one on every clock edge. Bits 31:16 of the readback show the live counter.
- R4: With select 0, an advance edge that finds the counter at zero reloads it with the programmed count. It also drives the interrupt request high for exactly the next clock cycle, so the timeout comes N+1 edges after a load of count N.
- R5: With select 1, a timeout holds the reset request high for exactly 16 clock cycles, starting in the cycle after the timeout edge. The interrupt request stays low.
- R6: A service write of 0x556C followed by a service write of 0xAA39 reloads the counter with the programmed count on the edge of the second write. Only bits 15:0 of the write data are compared, and bits 31:16 are ignored.
- R7: If any other service write follows 0x556C, the sequence drops back to waiting for 0x556C. A repeated 0x556C keeps the sequence armed. 0xAA39 without a preceding 0x556C does nothing.
- R8: The service readback is always zero.
- R9: With prescale 1, the counter advances once per 2048 clocks. A service or control reload restarts the prescaler, so a count of N times out 2048·(N+1) edges after the reload.
- R10: With freeze-mode 1 the counter holds while the freeze input is high. With freeze-mode 0 it keeps counting.
- R11: With enable 0 the counter holds its value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Debug halt indication |
| ctrl_wr_i | input | 1 | Control word write strobe |
| svc_wr_i | input | 1 | Service register write strobe |
| wdata_i | input | 32 | Write data for both registers |
| ctrl_rdata_o | output | 32 | Control readback with live count |
| svc_rdata_o | output | 16 | Service readback, always zero |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |
| sysrst_req_o | output | 1 | System reset request, held 16 cycles |

## Verification
A wrong key-sequence state shows up in the count field on the first read after the second key write. The count is either left reloaded or left decremented, one edge after the write. A counter or prescaler that is off by one moves the interrupt or reset edge by one clock, or by 2048 clocks when the prescaler is on, and the bench samples that exact cycle. A lock flag that is set wrongly shows up in the control readback at once, on the edge after the second control write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned CNT_W  = 16;
   localparam int unsigned BMT_W  = 8;
   localparam int unsigned KEY_W  = 16;

   typedef struct packed {
      logic [CNT_W-1:0] cnt;
      logic [BMT_W-1:0] bmt;
      logic             bme;
      logic [2:0]       rsv;
      logic             frz;
      logic             en;
      logic             sel;
      logic             pre;
   } cfg_t;

   localparam logic [WORD_W-1:0] CFG_RST = 32'hFFFF_FF07;
endpackage

// File: rtl/kwd_ctrl_reg.sv
module kwd_ctrl_reg
   import kwd_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output cfg_t              cfg_o,
   output logic              load_o,
   output logic              locked_o
);
   cfg_t cfg_q;
   cfg_t cfg_in;
   logic locked_q;

   always_comb begin
      cfg_in     = cfg_t'(wdata_i);
      cfg_in.rsv = '0;
   end

   assign load_o = wr_i & ~locked_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q    <= cfg_t'(CFG_RST);
         locked_q <= 1'b0;
      end else if (load_o) begin
         cfg_q    <= cfg_in;
         locked_q <= 1'b1;
      end
   end

   assign cfg_o    = cfg_q;
   assign locked_o = locked_q;
endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq #(
   parameter int unsigned       KW    = 16,
   parameter logic [KW-1:0]     KEY_A = 16'h556C,
   parameter logic [KW-1:0]     KEY_B = 16'hAA39
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic [KW-1:0] data_i,
   output logic          ok_o
);
   logic armed_q;

   assign ok_o = wr_i & armed_q & (data_i == KEY_B);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
      end else if (wr_i) begin
         armed_q <= (data_i == KEY_A);
      end
   end
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
   parameter int unsigned DIV = 2048
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic bypass_i,
   output logic tick_o
);
   localparam int unsigned PW      = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit          IS_POW2 = ((1 << PW) == DIV);

   logic tick_raw;

   if (IS_POW2) begin : g_pow2
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    pre_q <= '0;
         else if (clr_i) pre_q <= '0;
         else            pre_q <= pre_q + 1'b1;
      end
      assign tick_raw = &pre_q;
   end else begin : g_cmp
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap = (pre_q == PW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)            pre_q <= '0;
         else if (clr_i || wrap) pre_q <= '0;
         else                    pre_q <= pre_q + 1'b1;
      end
      assign tick_raw = wrap;
   end

   assign tick_o = bypass_i | tick_raw;
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         adv_i,
   output logic [W-1:0] cnt_o,
   output logic         tmo_o
);
   logic [W-1:0] cnt_q;

   assign tmo_o = adv_i & ~load_i & (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '1;
      else if (load_i || tmo_o) cnt_q <= load_val_i;
      else if (adv_i)           cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/kwd_fault_out.sv
module kwd_fault_out #(
   parameter int unsigned HOLD = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tmo_i,
   input  logic sel_i,
   output logic nmi_o,
   output logic rst_o
);
   localparam int unsigned HW = $clog2(HOLD + 1);

   logic [HW-1:0] hold_q;
   logic          nmi_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= '0;
         nmi_q  <= 1'b0;
      end else begin
         nmi_q <= tmo_i & ~sel_i;
         if (tmo_i && sel_i)    hold_q <= HW'(HOLD);
         else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      end
   end

   assign nmi_o = nmi_q;
   assign rst_o = (hold_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int unsigned     PRE_DIV  = 2048,
   parameter int unsigned     RST_HOLD = 16,
   parameter logic [KEY_W-1:0] KEY_A   = 16'h556C,
   parameter logic [KEY_W-1:0] KEY_B   = 16'hAA39
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              freeze_i,
   input  logic              ctrl_wr_i,
   input  logic              svc_wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] ctrl_rdata_o,
   output logic [KEY_W-1:0]  svc_rdata_o,
   output logic              nmi_req_o,
   output logic              sysrst_req_o
);
   if (PRE_DIV < 2) begin : g_bad_div
      $error("PRE_DIV must be at least 2");
   end
   if (RST_HOLD < 1) begin : g_bad_hold
      $error("RST_HOLD must be at least 1");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("service keys must differ");
   end

   cfg_t             cfg_w;
   logic             cfg_load_w;
   logic             locked_w;
   logic             svc_ok_w;
   logic             reload_w;
   logic             tick_w;
   logic             adv_w;
   logic             tmo_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] load_val_w;

   kwd_ctrl_reg u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (ctrl_wr_i),
      .wdata_i  (wdata_i),
      .cfg_o    (cfg_w),
      .load_o   (cfg_load_w),
      .locked_o (locked_w)
   );

   kwd_key_seq #(.KW(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (svc_wr_i),
      .data_i (wdata_i[KEY_W-1:0]),
      .ok_o   (svc_ok_w)
   );

   assign reload_w   = svc_ok_w | cfg_load_w;
   assign load_val_w = cfg_load_w ? wdata_i[WORD_W-1 -: CNT_W] : cfg_w.cnt;

   kwd_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (reload_w),
      .bypass_i (~cfg_w.pre),
      .tick_o   (tick_w)
   );

   assign adv_w = tick_w & cfg_w.en & ~(cfg_w.frz & freeze_i);

   kwd_counter #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (reload_w),
      .load_val_i (load_val_w),
      .adv_i      (adv_w),
      .cnt_o      (cnt_w),
      .tmo_o      (tmo_w)
   );

   kwd_fault_out #(.HOLD(RST_HOLD)) u_fault (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tmo_i  (tmo_w),
      .sel_i  (cfg_w.sel),
      .nmi_o  (nmi_req_o),
      .rst_o  (sysrst_req_o)
   );

   always_comb begin
      ctrl_rdata_o                     = WORD_W'(cfg_w);
      ctrl_rdata_o[WORD_W-1 -: CNT_W]  = cnt_w;
   end

   assign svc_rdata_o = '0;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
   import kwd_pkg::*;
(
   input logic             clk_i,
   input logic             rst_ni,
   input cfg_t             cfg,
   input logic             locked,
   input logic             cfg_load,
   input logic             svc_ok,
   input logic             reload,
   input logic             adv,
   input logic             tmo,
   input logic [CNT_W-1:0] cnt,
   input logic             nmi,
   input logic             sysrst
);
   // R2: once locked, stored fields never change
   p_locked_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked |=> $stable(cfg));

   // R3: an advance step from nonzero decrements by one
   p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && cnt != '0 && !reload) |=> (cnt == $past(cnt) - 1'b1));

   // R4: interrupt follows a timeout under select 0
   p_nmi_after_tmo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmo && !cfg.sel) |=> nmi);

   // R4: a single-cycle pulse when the reload count is nonzero
   p_nmi_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi && cfg.cnt != '0) |=> !nmi);

   // R5: reset request follows a timeout under select 1
   p_rst_after_tmo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmo && cfg.sel) |=> (sysrst && !nmi));

   // R6: valid key pair reloads programmed count
   p_svc_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_ok && !cfg_load) |=> (cnt == $past(cfg.cnt)));

   // R11: disabled counter holds
   p_hold_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg.en && !reload) |=> $stable(cnt));
endmodule

bind keyed_watchdog kwd_checker u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .cfg      (cfg_w),
   .locked   (locked_w),
   .cfg_load (cfg_load_w),
   .svc_ok   (svc_ok_w),
   .reload   (reload_w),
   .adv      (adv_w),
   .tmo      (tmo_w),
   .cnt      (cnt_w),
   .nmi      (nmi_req_o),
   .sysrst   (sysrst_req_o)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic        svc_wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] ctrl_rd;
   logic [15:0] svc_rd;
   logic        nmi;
   logic        sysrst;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   keyed_watchdog dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .freeze_i     (freeze),
      .ctrl_wr_i    (ctrl_wr),
      .svc_wr_i     (svc_wr),
      .wdata_i      (wdata),
      .ctrl_rdata_o (ctrl_rd),
      .svc_rdata_o  (svc_rd),
      .nmi_req_o    (nmi),
      .sysrst_req_o (sysrst)
   );

   localparam logic [15:0] KA = 16'h556C;
   localparam logic [15:0] KB = 16'hAA39;

   // three service writes, then the index (1..3) of the write that reloads, 0 = none
   localparam int NV = 9;
   localparam logic [97:0] VEC [0:NV-1] = '{
      {32'(KA),          32'(KB), 32'h0000_0000, 2'd2},
      {32'(KB),          32'(KA), 32'(KB),       2'd3},
      {32'(KA),          32'(KA), 32'(KB),       2'd3},
      {32'(KA),    32'h0000_1234, 32'(KB),       2'd0},
      {32'(KA),          32'(KB), 32'(KB),       2'd2},
      {32'(KB),          32'(KB), 32'(KB),       2'd0},
      {32'(KA),    32'h5A5A_AA39, 32'h0000_0001, 2'd2},
      {32'(KA),          32'(KB), 32'(KA),       2'd2},
      {32'h0000_0000, 32'h0000_0000, 32'(KA),    2'd0}
   };

   function automatic logic [31:0] cfgw(input logic [15:0] n, input bit frz,
                                        input bit en, input bit sel, input bit pre);
      return {n, 8'hAB, 1'b1, 3'b000, frz, en, sel, pre};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ctrl_wr = 1'b0; svc_wr = 1'b0; freeze = 1'b0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [31:0] w);
      ctrl_wr = 1'b1; wdata = w;
      @(negedge clk);
      ctrl_wr = 1'b0; wdata = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int first;
      int cnt_hi;
      logic [15:0] expc;

      // R1 reset state
      do_reset();
      chk("R1 ctrl readback", ctrl_rd, 32'hFFFF_FF07);
      chk("R1 nmi low", 32'(nmi), 32'd0);
      chk("R1 reset req low", 32'(sysrst), 32'd0);
      chk("R8 service reads zero", 32'(svc_rd), 32'd0);

      // R2 write once, reserved bits dropped
      cfg_write(32'h000A_ABF0);
      chk("R2 first write stored", ctrl_rd, 32'h000A_AB80);
      cfg_write(32'h1234_5607);
      chk("R2 second write ignored", ctrl_rd, 32'h000A_AB80);
      svc_wr = 1'b1; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      svc_wr = 1'b0;
      chk("R8 service reads zero after write", 32'(svc_rd), 32'd0);

      // R3 decrement per clock
      do_reset();
      cfg_write(cfgw(16'd50, 0, 1, 0, 0));
      chk("R3 loaded", 32'(ctrl_rd[31:16]), 32'd50);
      repeat (5) @(negedge clk);
      chk("R3 after five edges", 32'(ctrl_rd[31:16]), 32'd45);

      // R6 R7 service sequence table
      for (int v = 0; v < NV; v++) begin
         do_reset();
         cfg_write(cfgw(16'd200, 0, 1, 0, 0));
         svc_wr = 1'b1;
         wdata = VEC[v][97:66]; @(negedge clk);
         wdata = VEC[v][65:34]; @(negedge clk);
         wdata = VEC[v][33:2];  @(negedge clk);
         svc_wr = 1'b0; wdata = '0;
         expc = 16'(197 + int'(VEC[v][1:0]));
         chk($sformatf("R6 R7 service vector %0d", v), 32'(ctrl_rd[31:16]), 32'(expc));
      end

      // R4 interrupt timeout, count 5 -> timeout on 6th edge
      do_reset();
      cfg_write(cfgw(16'd5, 0, 1, 0, 0));
      first = 0; cnt_hi = 0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (nmi) begin cnt_hi++; if (first == 0) first = i; end
         if (i == 5) chk("R4 count at zero", 32'(ctrl_rd[31:16]), 32'd0);
         if (i == 6) chk("R4 reloaded on timeout", 32'(ctrl_rd[31:16]), 32'd5);
         if (sysrst) chk("R4 no reset request", 32'(sysrst), 32'd0);
      end
      chk("R4 pulse edge", 32'(first), 32'd6);
      chk("R4 pulse width", 32'(cnt_hi), 32'd1);

      // R5 reset request, count 30 -> timeout on 31st edge
      do_reset();
      cfg_write(cfgw(16'd30, 0, 1, 1, 0));
      first = 0; cnt_hi = 0;
      for (int i = 1; i <= 50; i++) begin
         @(negedge clk);
         if (sysrst) begin cnt_hi++; if (first == 0) first = i; end
         if (nmi) chk("R5 no interrupt", 32'(nmi), 32'd0);
      end
      chk("R5 reset start", 32'(first), 32'd31);
      chk("R5 reset length", 32'(cnt_hi), 32'd16);

      // R11 disabled
      do_reset();
      cfg_write(cfgw(16'd3, 0, 0, 0, 0));
      cnt_hi = 0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (nmi) cnt_hi++;
      end
      chk("R11 count held", 32'(ctrl_rd[31:16]), 32'd3);
      chk("R11 no timeout", 32'(cnt_hi), 32'd0);

      // R10 freeze with freeze-mode 1
      do_reset();
      cfg_write(cfgw(16'd20, 1, 1, 0, 0));
      freeze = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 frozen hold", 32'(ctrl_rd[31:16]), 32'd20);
      freeze = 1'b0;
      @(negedge clk);
      chk("R10 resumes", 32'(ctrl_rd[31:16]), 32'd19);

      // R10 freeze with freeze-mode 0
      do_reset();
      cfg_write(cfgw(16'd20, 0, 1, 0, 0));
      freeze = 1'b1;
      repeat (5) @(negedge clk);
      freeze = 1'b0;
      chk("R10 runs through freeze", 32'(ctrl_rd[31:16]), 32'd15);

      // R9 prescale, count 1 -> timeout at edge 4096
      do_reset();
      cfg_write(cfgw(16'd1, 0, 1, 0, 1));
      for (int i = 1; i <= 4096; i++) begin
         @(negedge clk);
         if (i == 2047) chk("R9 before first tick", 32'(ctrl_rd[31:16]), 32'd1);
         if (i == 2048) chk("R9 first tick", 32'(ctrl_rd[31:16]), 32'd0);
         if (i == 4095) chk("R9 no early timeout", 32'(nmi), 32'd0);
         if (i == 4096) chk("R9 timeout edge", 32'(nmi), 32'd1);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule